// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This block moves bytes between a small store of configuration items and system memory. The store's items are addressed by a 16-bit key, and the block keeps a running offset into the current item. The host does not feed data through a register. It writes a short control record into memory and then writes that record's 64-bit address into the engine. The engine reads the record over a memory master port and decodes it. It can switch to a different item first. It then reads the item out to memory, skips over item bytes, or writes memory bytes into the item. When it is done, it stores a completion word back into the record.

The same item store can also be reached without DMA, through a selector port. That port takes a key write and then returns the current item's bytes one at a time, advancing the offset on each read. The DMA address window always reads back as a fixed 8-byte ASCII signature, so software can check that the engine is present. The memory master handles one request at a time. Each request is either a 32-bit word or a single byte, and it stays asserted until it is acknowledged.

Top module: `cfg_dma_engine`

## Requirements
- R1: The host window takes 4-byte writes and 8-byte writes. A 4-byte write at offset 0 latches the upper 32 bits of the record address. A 4-byte write at offset 4 supplies the lower 32 bits and starts a transfer. An 8-byte write at offset 0 supplies the whole address and starts a transfer. Every other write size or offset is ignored.
- R2: The latched upper address half is cleared to zero when a transfer starts. A later low-half-only write therefore addresses a record below 4 GiB.
- R3: The record is 16 bytes long and big-endian. It holds the control word at +0, the byte count at +4, the memory address upper half at +8 and the lower half at +12. On the 32-bit memory bus, the byte at address A travels in bits 31:24 of a word access at A. A byte access uses bits 7:0.
- R4: Control bit 3 (0x08) requests a selection before the data phase. The key is taken from bits 31:16 of the control word, and the item offset is reset to zero.
- R5: The operation is chosen by priority. Read (bit 1, 0x02) wins over write (bit 4, 0x10), which wins over skip (bit 2, 0x04). With none of these set, the count is treated as zero: no data access is made and the status is success. Item keys below NUM_ITEMS (4) are valid. Item k holds 2k+2 bytes, and byte i starts at 16(k+1)+i.
- R6: A read copies item bytes from the current offset to consecutive memory addresses. Once the item is exhausted, or when the key is invalid, each remaining byte is written as zero.
- R7: A skip advances the item offset without touching memory. A skip past the end of the item is accepted without error.
- R8: A write stores memory bytes into the item. It raises the error status and stores nothing in three cases: the item is not writable (only key WR_KEY = 3 is writable), the item is invalid or exhausted, or fewer bytes remain in the item than the count.
- R9: On completion the control word is overwritten with 0x00000000 on success or 0x00000001 on error. If fetching the record fails, the engine skips the data phase and writes 0x00000001.
- R10: An error response from memory during the data phase sets the error status and stops the transfer. The item offset keeps the bytes that had already completed.
- R11: A host read of the window at byte offset a with size n returns signature bytes a through a+n-1, most significant first. The signature is "CFGDMA01", with byte 0 = 'C'. Positions past byte 7 read as zero.
- R12: `busy` is high from the triggering write until the completion write is acknowledged. While busy, host address writes, triggers and selector accesses are ignored.
- R13: After reset, key 0 is selected at offset 0. A selector key write picks an item and resets the offset. `dat_rdata` shows the byte at the current offset, or zero when the item is exhausted or invalid. A `dat_rd` pulse advances the offset.
- R14: The memory master keeps one request outstanding. `mem_req`, `mem_addr`, `mem_we` and `mem_wide` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe for the DMA address window |
| reg_addr | input | 3 | Byte offset within the 8-byte window |
| reg_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| reg_wdata | input | 64 | Host write data, right-aligned |
| reg_rdata | output | 64 | Signature bytes for the current offset and size |
| busy | output | 1 | A transfer is in progress |
| sel_wr | input | 1 | Selector port key write |
| sel_key | input | 16 | Key to select |
| dat_rd | input | 1 | Consume the current item byte |
| dat_rdata | output | 8 | Item byte at the current offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_wide | output | 1 | 1 = 32-bit word, 0 = single byte |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed, valid with mem_ack |

## Verification
The bench sweeps every key from valid through invalid against every count from 0 to 10. This catches a design that stops at the item end instead of zero-filling, or one that writes past the count. It combines operation bits to expose a wrong priority order. It skips to mid-item and then reads without reselecting, which exposes an offset that is not carried between transfers. It issues writes that are one byte too long, aimed at read-only items, or aimed at exhausted items; a design that checks these cases too late would corrupt the item. It aborts transfers on a memory fault to catch an engine that runs on after an error. It also starts a transfer from a low-half-only write after a high half was latched, which exposes an address half that is never cleared.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  localparam int unsigned KEY_W = 16;

  // control word bit positions
  localparam int unsigned CB_ERR   = 0;
  localparam int unsigned CB_READ  = 1;
  localparam int unsigned CB_SKIP  = 2;
  localparam int unsigned CB_SEL   = 3;
  localparam int unsigned CB_WRITE = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_STEP, S_PUT, S_GET, S_WB
  } dma_state_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_READ, OP_WRITE, OP_SKIP
  } dma_op_e;

  // read > write > skip
  function automatic dma_op_e pick_op(input logic [31:0] ctl);
    if (ctl[CB_READ])  return OP_READ;
    if (ctl[CB_WRITE]) return OP_WRITE;
    if (ctl[CB_SKIP])  return OP_SKIP;
    return OP_NONE;
  endfunction

  // bytes ofs..ofs+nbytes-1 of a big-endian 8-byte constant, right-aligned
  function automatic logic [63:0] sig_slice(input logic [63:0] sig,
                                            input logic [2:0]  ofs,
                                            input logic [3:0]  nbytes);
    logic [63:0] t;
    t = sig << (8 * ofs);
    if (nbytes == 4'd0 || nbytes > 4'd8) return 64'd0;
    return t >> (64 - 8 * nbytes);
  endfunction

  function automatic logic [15:0] item_len(input int k);
    return 16'(2 * k + 2);
  endfunction

  function automatic logic [7:0] item_init(input int k, input int i);
    return 8'(16 * (k + 1) + i);
  endfunction

endpackage

// File: rtl/cfg_item_store.sv
module cfg_item_store
  import cfg_dma_pkg::*;
#(
  parameter int NUM_ITEMS = 4,
  parameter int MAX_LEN   = 8,
  parameter int WR_KEY    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [KEY_W-1:0] key,
  input  logic             adv,
  input  logic             we,
  input  logic [7:0]       wdata,
  output logic             valid,
  output logic [15:0]      remain,
  output logic [7:0]       rbyte,
  output logic             writable
);

  localparam int IDX_W = (NUM_ITEMS > 1) ? $clog2(NUM_ITEMS) : 1;
  localparam int OFS_W = $clog2(MAX_LEN + 1);
  localparam int IW    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic             cur_ok;
  logic [IDX_W-1:0] cur_idx;
  logic [OFS_W-1:0] ofs;
  logic [7:0]       mem [NUM_ITEMS][MAX_LEN];
  logic [15:0]      len_tab [NUM_ITEMS];
  logic [15:0]      cur_len;
  logic             have_byte;

  for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_len
    assign len_tab[g] = item_len(g);
  end

  assign cur_len   = cur_ok ? len_tab[cur_idx] : 16'd0;
  assign remain    = cur_len - 16'(ofs);
  assign have_byte = (remain != 16'd0);
  assign valid     = cur_ok;
  assign writable  = cur_ok && (cur_idx == IDX_W'(WR_KEY));
  assign rbyte     = have_byte ? mem[cur_idx][ofs[IW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ok  <= 1'b1;
      cur_idx <= '0;
      ofs     <= '0;
      for (int k = 0; k < NUM_ITEMS; k++)
        for (int i = 0; i < MAX_LEN; i++)
          mem[k][i] <= item_init(k, i);
    end else if (sel) begin
      cur_ok  <= (int'(key) < NUM_ITEMS);
      cur_idx <= IDX_W'(key);
      ofs     <= '0;
    end else if (we && writable && have_byte) begin
      mem[cur_idx][ofs[IW-1:0]] <= wdata;
      ofs <= ofs + 1'b1;
    end else if (adv && have_byte) begin
      ofs <= ofs + 1'b1;
    end
  end

  // R8: the engine only stores into the writable item
  a_r8_store_only_writable: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> writable);

  // R13: offset never passes the item end, and stays zero on an invalid key
  a_r13_ofs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ok |-> 16'(ofs) <= cur_len) and (!cur_ok |-> ofs == '0));

endmodule

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = "CFGDMA01"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [3:0]  size,
  input  logic [63:0] wdata,
  input  logic        busy,
  output logic [63:0] rdata,
  output logic        trig,
  output logic [63:0] base
);

  logic [31:0] hi_q;
  logic        wr_hi, wr_lo, wr_full;

  assign wr_hi   = wr && !busy && size == 4'd4 && addr == 3'd0;
  assign wr_lo   = wr && !busy && size == 4'd4 && addr == 3'd4;
  assign wr_full = wr && !busy && size == 4'd8 && addr == 3'd0;

  assign trig  = wr_lo || wr_full;
  assign base  = wr_full ? wdata : {hi_q, wdata[31:0]};
  assign rdata = sig_slice(SIGNATURE, addr, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (trig)  hi_q <= '0;
    else if (wr_hi) hi_q <= wdata[31:0];
  end

endmodule

// File: rtl/cfg_dma_fsm.sv
module cfg_dma_fsm
  import cfg_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [63:0]      base,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             st_sel,
  output logic [KEY_W-1:0] st_key,
  output logic             st_adv,
  output logic             st_we,
  output logic [7:0]       st_wdata,
  input  logic [15:0]      st_remain,
  input  logic [7:0]       st_byte,
  input  logic             st_writable
);

  dma_state_e  state;
  dma_op_e     op_q;
  logic [63:0] base_q, daddr_q;
  logic [31:0] ctl_q, len_q;
  logic [1:0]  idx_q;
  logic        err_q, from_item_q;
  logic [7:0]  wbyte_q;
  logic        done_ok;
  logic        unused_ctl;

  assign unused_ctl = ^{ctl_q[15:5], ctl_q[CB_ERR], ctl_q[CB_READ], ctl_q[CB_SKIP], ctl_q[CB_WRITE]};
  assign busy    = (state != S_IDLE);
  assign done_ok = mem_ack && !mem_err;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wide  = 1'b0;
    mem_addr  = daddr_q;
    mem_wdata = '0;
    st_sel    = 1'b0;
    st_key    = ctl_q[31:16];
    st_adv    = 1'b0;
    st_we     = 1'b0;
    st_wdata  = mem_rdata[7:0];
    unique case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_wide = 1'b1;
        mem_addr = base_q + {60'd0, idx_q, 2'b00};
      end
      S_DECODE: st_sel = ctl_q[CB_SEL];
      S_STEP:   st_adv = (len_q != 32'd0) && (op_q == OP_SKIP);
      S_PUT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {24'd0, wbyte_q};
        st_adv    = done_ok && from_item_q;
      end
      S_GET: begin
        mem_req = 1'b1;
        st_we   = done_ok;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wide  = 1'b1;
        mem_addr  = base_q;
        mem_wdata = {31'd0, err_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op_q        <= OP_NONE;
      base_q      <= '0;
      daddr_q     <= '0;
      ctl_q       <= '0;
      len_q       <= '0;
      idx_q       <= '0;
      err_q       <= 1'b0;
      from_item_q <= 1'b0;
      wbyte_q     <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (trig) begin
          base_q <= base;
          idx_q  <= '0;
          err_q  <= 1'b0;
          state  <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= S_WB;
          end else begin
            unique case (idx_q)
              2'd0: ctl_q          <= mem_rdata;
              2'd1: len_q          <= mem_rdata;
              2'd2: daddr_q[63:32] <= mem_rdata;
              default: daddr_q[31:0] <= mem_rdata;
            endcase
            idx_q <= idx_q + 2'd1;
            if (idx_q == 2'd3) state <= S_DECODE;
          end
        end
        S_DECODE: begin
          op_q <= pick_op(ctl_q);
          if (pick_op(ctl_q) == OP_NONE) len_q <= '0;
          state <= S_STEP;
        end
        S_STEP: begin
          if (len_q == 32'd0) begin
            state <= S_WB;
          end else begin
            unique case (op_q)
              OP_READ: begin
                wbyte_q     <= st_byte;
                from_item_q <= (st_remain != 16'd0);
                state       <= S_PUT;
              end
              OP_SKIP: begin
                len_q   <= len_q - 32'd1;
                daddr_q <= daddr_q + 64'd1;
              end
              OP_WRITE: begin
                if (st_remain == 16'd0 || !st_writable || {16'd0, st_remain} < len_q) begin
                  err_q <= 1'b1;
                  state <= S_WB;
                end else begin
                  state <= S_GET;
                end
              end
              default: state <= S_WB;
            endcase
          end
        end
        S_PUT, S_GET: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= S_WB;
          end else begin
            len_q   <= len_q - 32'd1;
            daddr_q <= daddr_q + 64'd1;
            state   <= S_STEP;
          end
        end
        S_WB: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R14: a request is held unchanged until acknowledged
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wide)));

  // R9: word writes only go to the record's control word, carrying 0 or 1
  a_r9_status_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wide) |-> (mem_wdata[31:1] == 31'd0 && mem_addr == base_q));

  // R8: an item store write is only issued on a successful memory byte read
  a_r8_we_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (mem_ack && !mem_err && !mem_we && !mem_wide));

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int          NUM_ITEMS = 4,
  parameter int          MAX_LEN   = 8,
  parameter int          WR_KEY    = 3,
  parameter logic [63:0] SIGNATURE = "CFGDMA01"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [3:0]  reg_size,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        busy,
  input  logic        sel_wr,
  input  logic [15:0] sel_key,
  input  logic        dat_rd,
  output logic [7:0]  dat_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_wide,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err
);

  logic             trig;
  logic [63:0]      base;
  logic             f_sel, f_adv, f_we;
  logic [KEY_W-1:0] f_key;
  logic [7:0]       f_wdata;
  logic             s_sel, s_adv;
  logic [KEY_W-1:0] s_key;
  logic             st_valid, st_writable;
  logic [15:0]      st_remain;
  logic [7:0]       st_byte;
  logic             unused_valid;

  assign unused_valid = st_valid;

  cfg_dma_regs #(.SIGNATURE(SIGNATURE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .size(reg_size),
    .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata), .trig(trig), .base(base)
  );

  cfg_dma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trig(trig), .base(base), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .st_sel(f_sel), .st_key(f_key), .st_adv(f_adv), .st_we(f_we), .st_wdata(f_wdata),
    .st_remain(st_remain), .st_byte(st_byte), .st_writable(st_writable)
  );

  // selector port owns the store only while the engine is idle
  assign s_sel = busy ? f_sel : sel_wr;
  assign s_key = busy ? f_key : sel_key;
  assign s_adv = busy ? f_adv : dat_rd;

  cfg_item_store #(.NUM_ITEMS(NUM_ITEMS), .MAX_LEN(MAX_LEN), .WR_KEY(WR_KEY)) u_store (
    .clk(clk), .rst_n(rst_n), .sel(s_sel), .key(s_key), .adv(s_adv),
    .we(f_we), .wdata(f_wdata), .valid(st_valid), .remain(st_remain),
    .rbyte(st_byte), .writable(st_writable)
  );

  assign dat_rdata = st_byte;

  // R6: a byte written to memory while the item is exhausted is zero
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wide && st_remain == 16'd0) |-> mem_wdata[7:0] == 8'h00);

  // R12: the selector port cannot move the store during a transfer
  a_r12_host_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !f_sel && !f_adv && !f_we) |=> $stable(st_remain));

endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;
  localparam logic [63:0] SIG_EXP = "CFGDMA01";
  localparam logic [31:0] C_RD = 32'h02, C_SK = 32'h04, C_SEL = 32'h08, C_WR = 32'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [3:0]  reg_size = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        busy;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_key = '0;
  logic        dat_rd = 1'b0;
  logic [7:0]  dat_rdata;
  logic        mem_req, mem_we, mem_wide;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;

  logic [7:0] bmem [256];
  logic [7:0] shadow [4][8];
  int n_chk = 0, n_fail = 0, n_word = 0, n_byte = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .sel_wr(sel_wr),
    .sel_key(sel_key), .dat_rd(dat_rd), .dat_rdata(dat_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
  );

  function automatic int exp_len(input int k);
    return (k < 4) ? 2 * k + 2 : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_w32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) bmem[(a + b) & 255] = v[31 - 8 * b -: 8];
  endtask

  function automatic logic [31:0] get_w32(input int a);
    return {bmem[a & 255], bmem[(a + 1) & 255], bmem[(a + 2) & 255], bmem[(a + 3) & 255]};
  endfunction

  task automatic put_desc(input int base, input logic [31:0] ctl, input int len, input int addr);
    put_w32(base, ctl);
    put_w32(base + 4, 32'(len));
    put_w32(base + 8, 32'd0);
    put_w32(base + 12, 32'(addr));
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) check(1'b0, "R12 busy never dropped", 1, 0);
  endtask

  task automatic run(input int base, input logic [31:0] ctl, input int len, input int addr);
    put_desc(base, ctl, len, addr);
    n_word = 0; n_byte = 0;
    host_wr(3'd0, 4'd8, 64'(base));
    wait_idle();
  endtask

  task automatic do_sel(input int k);
    @(negedge clk);
    sel_wr = 1'b1; sel_key = 16'(k);
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic do_next();
    @(negedge clk);
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  // item k from offset 0 via the selector port against the bench model
  task automatic check_item(input int k, input string tag);
    int bad;
    logic [7:0] e, got_first;
    bad = 0;
    got_first = 0;
    do_sel(k);
    for (int i = 0; i < 10; i++) begin
      e = (i < exp_len(k)) ? shadow[k][i] : 8'h00;
      if (dat_rdata !== e) begin
        bad++;
        if (bad == 1) got_first = dat_rdata;
      end
      do_next();
    end
    check(bad == 0, tag, got_first, bad);
  endtask

  task automatic fill_dest(input int a, input int n);
    for (int i = 0; i < n; i++) bmem[(a + i) & 255] = 8'hEE;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++) shadow[k][i] = 8'(16 * k + 16 + i);

    fork
      forever begin
        @(posedge clk);
        if (mem_req && !mem_ack) begin
          mem_ack <= 1'b1;
          mem_err <= (mem_addr >= 64'd256);
          if (mem_wide) n_word++; else n_byte++;
          if (mem_addr < 64'd256) begin
            if (mem_we) begin
              if (mem_wide) put_w32(int'(mem_addr), mem_wdata);
              else bmem[mem_addr[7:0]] = mem_wdata[7:0];
            end else begin
              mem_rdata <= mem_wide ? get_w32(int'(mem_addr)) : {24'd0, bmem[mem_addr[7:0]]};
            end
          end
        end else begin
          mem_ack <= 1'b0;
          mem_err <= 1'b0;
        end
      end
      begin
        while (cyc < WDOG_LIMIT) begin
          @(posedge clk);
          cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL R14 watchdog expired actual=%0d expected<%0d", cyc, WDOG_LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check(busy == 1'b0 && mem_req == 1'b0, "R12 idle after reset", {busy, mem_req}, 0);
    check(dat_rdata == 8'h10, "R13 key 0 offset 0 after reset", dat_rdata, 8'h10);

    // R11 signature sweep
    for (int a = 0; a < 8; a++) begin
      for (int s = 1; s <= 8; s = s * 2) begin
        logic [63:0] e;
        e = 0;
        for (int b = 0; b < s; b++)
          e = (e << 8) | ((a + b < 8) ? 64'(SIG_EXP[63 - 8 * (a + b) -: 8]) : 64'd0);
        @(negedge clk);
        reg_addr = 3'(a); reg_size = 4'(s);
        #1;
        check(reg_rdata == e, "R11 signature slice", reg_rdata, e);
      end
    end

    // R13 selector sweep over valid and invalid keys
    for (int k = 0; k < 6; k++) check_item(k, "R13 selector port item bytes");

    // R3 R4 R6 R9 read sweep: every key against counts 0..10
    for (int k = 0; k < 6; k++) begin
      for (int n = 0; n <= 10; n++) begin
        int bad;
        fill_dest(128, 16);
        run(0, {16'(k), 16'd0} | C_SEL | C_RD, n, 128);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
          logic [7:0] e;
          e = (i >= n) ? 8'hEE : ((i < exp_len(k)) ? shadow[k][i] : 8'h00);
          if (bmem[128 + i] !== e) bad++;
        end
        check(bad == 0, "R3 R4 R6 read with zero fill", bad, 0);
        check(get_w32(0) == 32'd0, "R9 success status", get_w32(0), 0);
      end
    end

    // R5 priority: read wins over write and skip
    fill_dest(128, 8);
    run(0, {16'd1, 16'd0} | C_SEL | C_RD | C_WR | C_SK, 3, 128);
    check(bmem[128] == 8'h20 && bmem[130] == 8'h22 && bmem[131] == 8'hEE,
          "R5 read priority", {bmem[128], bmem[130], bmem[131]}, 24'h2022EE);
    // R5 write wins over skip
    bmem[144] = 8'hA1; bmem[145] = 8'hA2;
    run(0, {16'd3, 16'd0} | C_SEL | C_WR | C_SK, 2, 144);
    shadow[3][0] = 8'hA1; shadow[3][1] = 8'hA2;
    check(get_w32(0) == 32'd0, "R5 write over skip status", get_w32(0), 0);
    check_item(3, "R5 R8 write over skip stored");
    // R5 no operation bit: count ignored, record fetch then status only
    fill_dest(128, 8);
    run(0, {16'd2, 16'd0} | C_SEL, 5, 128);
    check(n_byte == 0 && n_word == 5, "R5 R14 no-op traffic", n_byte * 16 + n_word, 5);
    check(bmem[128] == 8'hEE && get_w32(0) == 0, "R5 no-op dest untouched", bmem[128], 8'hEE);
    check(dat_rdata == 8'h30, "R4 R5 select still applied", dat_rdata, 8'h30);

    // R7 skip without memory traffic
    run(0, {16'd2, 16'd0} | C_SEL | C_SK, 3, 128);
    check(n_byte == 0, "R7 skip has no byte traffic", n_byte, 0);
    check(dat_rdata == 8'h33, "R7 skip advanced offset", dat_rdata, 8'h33);
    run(0, {16'd0, 16'd0} | C_SEL | C_SK, 5, 128);
    check(get_w32(0) == 0 && dat_rdata == 8'h00, "R7 skip past end no error", get_w32(0), 0);

    // R6 offset carried between transfers
    run(0, {16'd1, 16'd0} | C_SEL | C_SK, 2, 128);
    fill_dest(128, 8);
    run(0, C_RD, 5, 128);
    check(bmem[128] == 8'h22 && bmem[129] == 8'h23 && bmem[130] == 0 && bmem[132] == 0 && bmem[133] == 8'hEE,
          "R6 continue then zero fill", {bmem[128], bmem[129], bmem[130]}, 24'h222300);

    // R8 full write to the writable item
    for (int i = 0; i < 8; i++) bmem[144 + i] = 8'(8'h50 + i);
    run(0, {16'd3, 16'd0} | C_SEL | C_WR, 8, 144);
    for (int i = 0; i < 8; i++) shadow[3][i] = 8'(8'h50 + i);
    check(get_w32(0) == 0, "R8 full write status", get_w32(0), 0);
    check_item(3, "R8 full write stored");
    // R8 error cases
    bmem[144] = 8'hCC;
    run(0, {16'd1, 16'd0} | C_SEL | C_WR, 1, 144);
    check(get_w32(0) == 32'd1, "R8 read-only item error", get_w32(0), 1);
    check_item(1, "R8 read-only item unchanged");
    run(0, {16'd3, 16'd0} | C_SEL | C_WR, 9, 144);
    check(get_w32(0) == 32'd1 && n_byte == 0, "R8 too long error", get_w32(0), 1);
    check_item(3, "R8 too long stores nothing");
    run(0, {16'd6, 16'd0} | C_SEL | C_WR, 1, 144);
    check(get_w32(0) == 32'd1, "R8 invalid key error", get_w32(0), 1);
    run(0, {16'd3, 16'd0} | C_SEL | C_SK, 8, 144);
    run(0, C_WR, 1, 144);
    check(get_w32(0) == 32'd1 && n_byte == 0, "R8 exhausted item error", get_w32(0), 1);

    // R10 memory fault during data phase
    run(0, {16'd2, 16'd0} | C_SEL | C_RD, 4, 254);
    check(get_w32(0) == 32'd1, "R10 fault status", get_w32(0), 1);
    check(bmem[254] == 8'h30 && bmem[255] == 8'h31 && n_byte == 3, "R10 stop after fault",
          n_byte, 3);
    check(dat_rdata == 8'h32, "R10 offset keeps completed bytes", dat_rdata, 8'h32);

    // R9 record fetch fault: no data phase
    n_word = 0; n_byte = 0;
    host_wr(3'd0, 4'd8, 64'h1000);
    wait_idle();
    check(n_word == 2 && n_byte == 0, "R9 fetch fault skips data", n_word, 2);

    // R1 split address write and R2 clearing of the high half
    put_desc(64, {16'd0, 16'd0} | C_SEL | C_RD, 2, 128);
    fill_dest(128, 4);
    host_wr(3'd0, 4'd4, 64'd0);
    check(busy == 1'b0, "R1 high half does not trigger", busy, 0);
    host_wr(3'd4, 4'd4, 64'd64);
    wait_idle();
    check(get_w32(64) == 0 && bmem[128] == 8'h10 && bmem[129] == 8'h11, "R1 split trigger",
          get_w32(64), 0);
    n_word = 0;
    host_wr(3'd0, 4'd4, 64'd5);
    host_wr(3'd4, 4'd4, 64'd64);
    wait_idle();
    check(n_word == 2, "R1 high half used in address", n_word, 2);
    put_desc(64, {16'd0, 16'd0} | C_SEL | C_RD, 2, 128);
    host_wr(3'd4, 4'd4, 64'd64);
    wait_idle();
    check(get_w32(64) == 0, "R2 high half cleared at start", get_w32(64), 0);
    // R1 ignored write shapes
    put_desc(64, C_SEL | C_RD, 2, 128);
    n_word = 0;
    host_wr(3'd0, 4'd2, 64'd64);
    host_wr(3'd4, 4'd8, 64'd64);
    host_wr(3'd0, 4'd1, 64'd64);
    host_wr(3'd2, 4'd4, 64'd64);
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && n_word == 0, "R1 other shapes ignored", n_word, 0);

    // R12 writes while busy are ignored
    put_desc(64, C_SEL | C_RD, 10, 128);
    put_desc(96, C_SEL | C_RD, 1, 128);
    host_wr(3'd0, 4'd8, 64'd64);
    check(busy == 1'b1, "R12 busy after trigger", busy, 1);
    host_wr(3'd0, 4'd8, 64'd96);
    host_wr(3'd0, 4'd4, 64'd7);
    wait_idle();
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && get_w32(96) == (C_SEL | C_RD), "R12 trigger while busy ignored",
          get_w32(96), C_SEL | C_RD);
    put_desc(64, C_SEL | C_RD, 1, 128);
    host_wr(3'd4, 4'd4, 64'd64);
    wait_idle();
    check(get_w32(64) == 0, "R12 high write while busy ignored", get_w32(64), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule